// File: doc/BRIEF.md
# TDM Time-Slot Routing Sequencer

This block sits on a serial time-division-multiplexed line and decides, one bit clock at a time, which internal channel owns the current bit of a frame. It has two routing tables, one for receive and one for transmit. Each table holds small entries, and each entry names a destination channel, a run length in bits or bytes, a set of external strobes and a flag that marks the final entry. The two sides share one bit clock, one frame-sync pulse and one enable, but each side steps through its own table. Receive routing appears as per-channel data-valid strobes. Transmit routing appears as per-channel request strobes and an open-drain style serial output.

One channel code routes no data. Instead it marks a single bit whose receive line value is captured as the collision grant for the D-channel controller. The captured grant is held until the next such bit. Software loads the tables through a simple write port while the block is disabled. Once enabled, sequencing begins at the next frame sync and stops at the last entry, at the end of the table, or after the frame length, whichever comes first.

Top module: `slot_router`

## Requirements
- R1: A table write takes place on a clock edge where `wrEn` is 1 and `enable` is 0. Address bit AW selects the table: 0 is receive and 1 is transmit. The lower AW bits give the entry index. The `wrData` layout is: [2:0] channel code, [6:3] strobe mask, [10:7] count, [11] unit flag with 1 meaning byte, and [12] last flag. A write attempted while `enable` is 1 is ignored. After reset every entry holds only the last flag set.
- R2: After reset all strobes are 0, `txLine` is 1 and `dGrant` is 0. A clock edge with `frameSync` and `enable` both 1 starts both sides at entry 0. The bit slot that follows that edge is frame bit 0. A clock edge with `enable` at 0 makes both sides idle from the next cycle on.
- R3: An entry lasts count+1 units. A unit is 8 bits when the unit flag is 1 and 1 bit when it is 0.
- R4: On each active side, channel code 010 drives strobe index 0 (D channel), 101 drives index 1 (management 1) and 110 drives index 2 (management 2), on `rxValid` or `txReq`. Every other code drives no channel strobe.
- R5: While an entry is active, its 4-bit strobe mask appears on `rxStrobe` (receive side) or `txStrobe` (transmit side). Otherwise these outputs are 0.
- R6: A receive entry with channel code 111 captures `rxLine` at the end of each bit it covers into `dGrant`. `dGrant` changes at no other time.
- R7: A side goes idle after finishing an entry with the last flag set, or after finishing the final table entry. It stays idle until the next frame sync.
- R8: A side goes idle after FRAME_BITS (default 96) bits of a frame, even if its current entry has not finished.
- R9: `txLine` carries `txData[k]` while transmit strobe k is active. In every other bit it is 1, the released state.
- R10: A frame sync that arrives while a side is active restarts that side at entry 0, bit 0.
- R11: The receive and transmit tables are independent. Writing one table does not change the routing of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Sequencing enable; while high, table writes are blocked |
| frameSync | input | 1 | Frame-start pulse |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | AW+1 | Table select (MSB) and entry index |
| wrData | input | 13 | Entry word |
| rxLine | input | 1 | Serial receive line |
| txData | input | 3 | Transmit bit from each channel (index 0 D, 1 management 1, 2 management 2) |
| rxValid | output | 3 | Receive bit valid per channel |
| txReq | output | 3 | Transmit bit request per channel |
| rxStrobe | output | 4 | External strobes, receive side |
| txStrobe | output | 4 | External strobes, transmit side |
| txLine | output | 1 | Serial transmit line, 1 when released |
| dGrant | output | 1 | Captured D-channel grant |

## Verification
Two events can fall in the same edge: a frame sync that restarts sequencing, and the normal end of a run that would step to the next entry or end the frame. The bench provokes this by issuing a sync in the middle of a long entry and again in the slot right after the last entry. It judges the result by comparing every output, on every cycle, with a behavioural model in which the sync takes priority. A second collision is a grant capture combined with the last entry. Here the bench checks that `dGrant` takes the forced line value and then holds it across the idle tail and the next frame's early bits.

// File: rtl/slot_router_pkg.sv
package slot_router_pkg;
  localparam int CHAN_W  = 3;
  localparam int STRB_W  = 4;
  localparam int CNT_W   = 4;
  localparam int NUM_CH  = 3;
  localparam int RUN_W   = CNT_W + 3;

  typedef struct packed {
    logic              last;
    logic              byteUnit;
    logic [CNT_W-1:0]  cnt;
    logic [STRB_W-1:0] strb;
    logic [CHAN_W-1:0] chan;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  localparam logic [CHAN_W-1:0] CH_D     = 3'b010;
  localparam logic [CHAN_W-1:0] CH_M1    = 3'b101;
  localparam logic [CHAN_W-1:0] CH_M2    = 3'b110;
  localparam logic [CHAN_W-1:0] CH_GRANT = 3'b111;

  typedef struct packed {
    logic [RUN_W-1:0] lastRun;
    logic             stop;
  } seqInfo_t;

  typedef struct packed {
    logic [1:0] active;
    logic [1:0] restart;
    logic [1:0] advance;
  } ctl_t;
endpackage

// File: rtl/slot_router_ctrl.sv
module slot_router_ctrl
  import slot_router_pkg::*;
#(
  parameter int FRAME_BITS = 96,
  localparam int FB_W = $clog2(FRAME_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                frameSync,
  input  seqInfo_t [1:0]      info,
  output ctl_t                ctl
);
  logic [1:0] actV, restartV, advanceV;

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic             act;
    logic [RUN_W-1:0] run;
    logic [FB_W-1:0]  fb;
    logic             runEnd, fbEnd;

    assign runEnd = (run == info[s].lastRun);
    assign fbEnd  = (fb == FB_W'(FRAME_BITS - 1));

    assign actV[s]     = act;
    assign restartV[s] = enable & frameSync;
    assign advanceV[s] = enable & ~frameSync & act & runEnd & ~fbEnd & ~info[s].stop;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        act <= 1'b0;
        run <= '0;
        fb  <= '0;
      end else if (!enable) begin
        act <= 1'b0;
      end else if (frameSync) begin
        act <= 1'b1;
        run <= '0;
        fb  <= '0;
      end else if (act) begin
        fb <= fb + 1'b1;
        if (fbEnd) begin
          act <= 1'b0;
        end else if (runEnd) begin
          run <= '0;
          if (info[s].stop) act <= 1'b0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  end

  assign ctl = '{active: actV, restart: restartV, advance: advanceV};
endmodule

// File: rtl/slot_router_dp.sv
module slot_router_dp
  import slot_router_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                wrEn,
  input  logic [AW:0]         wrAddr,
  input  logic [ENTRY_W-1:0]  wrData,
  input  logic                rxLine,
  input  logic [NUM_CH-1:0]   txData,
  input  ctl_t                ctl,
  output seqInfo_t [1:0]      info,
  output logic                grantStb,
  output logic [NUM_CH-1:0]   rxValid,
  output logic [NUM_CH-1:0]   txReq,
  output logic [STRB_W-1:0]   rxStrobe,
  output logic [STRB_W-1:0]   txStrobe,
  output logic                txLine,
  output logic                dGrant
);
  entry_t tbl [2][DEPTH];
  entry_t cur [2];
  logic [NUM_CH-1:0] chanHit [2];

  function automatic logic [NUM_CH-1:0] decodeChan(input logic [CHAN_W-1:0] c);
    case (c)
      CH_D:    return 3'b001;
      CH_M1:   return 3'b010;
      CH_M2:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < DEPTH; i++)
          tbl[s][i] <= '{last: 1'b1, default: '0};
    end else if (wrEn && !enable) begin
      tbl[wrAddr[AW]][wrAddr[AW-1:0]] <= entry_t'(wrData);
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [AW-1:0] idx;

    always_ff @(posedge clk) begin
      if (!rstN)                idx <= '0;
      else if (ctl.restart[s])  idx <= '0;
      else if (ctl.advance[s])  idx <= idx + 1'b1;
    end

    assign cur[s]          = tbl[s][idx];
    assign info[s].lastRun = cur[s].byteUnit ? {cur[s].cnt, 3'b111} : {3'b000, cur[s].cnt};
    assign info[s].stop    = cur[s].last | (idx == AW'(DEPTH - 1));
    assign chanHit[s]      = ctl.active[s] ? decodeChan(cur[s].chan) : '0;
  end

  assign grantStb = ctl.active[0] & (cur[0].chan == CH_GRANT);

  always_ff @(posedge clk) begin
    if (!rstN)         dGrant <= 1'b0;
    else if (grantStb) dGrant <= rxLine;
  end

  assign rxValid  = chanHit[0];
  assign txReq    = chanHit[1];
  assign rxStrobe = ctl.active[0] ? cur[0].strb : '0;
  assign txStrobe = ctl.active[1] ? cur[1].strb : '0;
  assign txLine   = (|chanHit[1]) ? |(chanHit[1] & txData) : 1'b1;
endmodule

// File: rtl/slot_router.sv
module slot_router
  import slot_router_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FRAME_BITS = 96,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                frameSync,
  input  logic                wrEn,
  input  logic [AW:0]         wrAddr,
  input  logic [ENTRY_W-1:0]  wrData,
  input  logic                rxLine,
  input  logic [NUM_CH-1:0]   txData,
  output logic [NUM_CH-1:0]   rxValid,
  output logic [NUM_CH-1:0]   txReq,
  output logic [STRB_W-1:0]   rxStrobe,
  output logic [STRB_W-1:0]   txStrobe,
  output logic                txLine,
  output logic                dGrant
);
  ctl_t           ctl;
  seqInfo_t [1:0] info;
  logic           grantStb;

  slot_router_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .frameSync(frameSync),
    .info(info), .ctl(ctl)
  );

  slot_router_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rxLine(rxLine), .txData(txData), .ctl(ctl),
    .info(info), .grantStb(grantStb), .rxValid(rxValid), .txReq(txReq),
    .rxStrobe(rxStrobe), .txStrobe(txStrobe), .txLine(txLine), .dGrant(dGrant)
  );
endmodule

// File: rtl/slot_router_chk.sv
module slot_router_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       rxLine,
  input logic       grantStb,
  input logic [2:0] rxValid,
  input logic [2:0] txReq,
  input logic [3:0] rxStrobe,
  input logic [3:0] txStrobe,
  input logic       txLine,
  input logic       dGrant
);
  a_r6_grant_hold: assert property (@(posedge clk) disable iff (!rstN)
    !grantStb |=> $stable(dGrant));

  a_r6_grant_capture: assert property (@(posedge clk) disable iff (!rstN)
    grantStb |=> (dGrant == $past(rxLine)));

  a_r6_grant_no_route: assert property (@(posedge clk) disable iff (!rstN)
    grantStb |-> (rxValid == 3'b000));

  a_r2_disable_idle: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (rxValid == 3'b000 && txReq == 3'b000 &&
                 rxStrobe == 4'b0000 && txStrobe == 4'b0000));

  a_r9_line_released: assert property (@(posedge clk) disable iff (!rstN)
    (txReq == 3'b000) |-> txLine);

  a_r4_single_channel: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rxValid) && $onehot0(txReq));
endmodule

bind slot_router slot_router_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .rxLine(rxLine),
  .grantStb(grantStb), .rxValid(rxValid), .txReq(txReq),
  .rxStrobe(rxStrobe), .txStrobe(txStrobe), .txLine(txLine), .dGrant(dGrant)
);

// File: tb/slot_router_tb.sv
module slot_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int FRAME_BITS = 96;

  logic clk = 1'b0;
  logic rstN = 1'b0, enable = 1'b0, frameSync = 1'b0, wrEn = 1'b0, rxLine = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [12:0] wrData = '0;
  logic [2:0]  txData = '0;
  logic [2:0]  rxValid, txReq;
  logic [3:0]  rxStrobe, txStrobe;
  logic        txLine, dGrant;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  logic [12:0] mTbl [2][DEPTH];
  int mAct [2], mIdx [2], mRun [2], mFb [2];
  logic mGrant;

  // per-frame counters of observed outputs
  int cRx [3], cTx [3], cRxStb, cTxStb, cLineLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_router #(.DEPTH(DEPTH), .FRAME_BITS(FRAME_BITS)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .frameSync(frameSync),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rxLine(rxLine),
    .txData(txData), .rxValid(rxValid), .txReq(txReq), .rxStrobe(rxStrobe),
    .txStrobe(txStrobe), .txLine(txLine), .dGrant(dGrant)
  );

  function automatic logic [12:0] mk(int chan, int strb, int cnt, int unit, int last);
    return {last[0], unit[0], cnt[3:0], strb[3:0], chan[2:0]};
  endfunction

  function automatic logic [2:0] chanBits(logic [2:0] c);
    if (c == 3'b010) return 3'b001;
    if (c == 3'b101) return 3'b010;
    if (c == 3'b110) return 3'b100;
    return 3'b000;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < 2; s++) begin
        mAct[s] = 0; mIdx[s] = 0; mRun[s] = 0; mFb[s] = 0;
        for (int i = 0; i < DEPTH; i++) mTbl[s][i] = 13'h1000;
      end
      mGrant = 1'b0;
    end else begin
      if (mAct[0] != 0 && mTbl[0][mIdx[0]][2:0] == 3'b111) mGrant = rxLine;
      for (int s = 0; s < 2; s++) begin
        logic [12:0] e;
        int len;
        e = mTbl[s][mIdx[s]];
        len = (int'(e[10:7]) + 1) * (e[11] ? 8 : 1);
        if (!enable) mAct[s] = 0;
        else if (frameSync) begin
          mAct[s] = 1; mIdx[s] = 0; mRun[s] = 0; mFb[s] = 0;
        end else if (mAct[s] != 0) begin
          if (mFb[s] == FRAME_BITS - 1) mAct[s] = 0;
          else if (mRun[s] == len - 1) begin
            mRun[s] = 0;
            if (e[12] || mIdx[s] == DEPTH - 1) mAct[s] = 0;
            else mIdx[s] = mIdx[s] + 1;
          end else mRun[s] = mRun[s] + 1;
          mFb[s] = mFb[s] + 1;
        end
      end
      if (wrEn && !enable) mTbl[wrAddr[4]][wrAddr[3:0]] = wrData;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [12:0] er, et;
    logic [2:0] xRx, xTx;
    logic [3:0] xRs, xTs;
    logic xLine;
    er = mTbl[0][mIdx[0]];
    et = mTbl[1][mIdx[1]];
    xRx = mAct[0] != 0 ? chanBits(er[2:0]) : 3'b000;
    xTx = mAct[1] != 0 ? chanBits(et[2:0]) : 3'b000;
    xRs = mAct[0] != 0 ? er[6:3] : 4'b0000;
    xTs = mAct[1] != 0 ? et[6:3] : 4'b0000;
    xLine = (xTx == 3'b000) ? 1'b1 : |(xTx & txData);
    chk(rxValid == xRx, "R4 rxValid", rxValid, xRx);
    chk(txReq == xTx, "R4 txReq", txReq, xTx);
    chk(rxStrobe == xRs && txStrobe == xTs, "R5 strobes", {rxStrobe, txStrobe}, {xRs, xTs});
    chk(txLine == xLine, "R9 txLine", txLine, xLine);
    chk(dGrant == mGrant, "R6 dGrant", dGrant, mGrant);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
    for (int k = 0; k < 3; k++) begin
      cRx[k] += rxValid[k];
      cTx[k] += txReq[k];
    end
    cRxStb += (rxStrobe != 0);
    cTxStb += (txStrobe != 0);
    cLineLow += (txReq == 0 && txLine == 0);
  endtask

  task automatic clearCounts();
    for (int k = 0; k < 3; k++) begin cRx[k] = 0; cTx[k] = 0; end
    cRxStb = 0; cTxStb = 0; cLineLow = 0;
  endtask

  task automatic wr(int side, int idx, logic [12:0] d);
    wrEn = 1'b1; wrAddr = {side[0], idx[3:0]}; wrData = d;
    cyc();
    wrEn = 1'b0;
  endtask

  // sync slot then nbits further slots; line forced to g at frame bit 90
  task automatic frame(int nbits, bit g, bit clr);
    if (clr) clearCounts();
    frameSync = 1'b1;
    rxLine = 1'($urandom);
    txData = 3'($urandom);
    cyc();
    for (int k = 0; k < nbits; k++) begin
      frameSync = 1'b0;
      rxLine = (k == 90) ? g : 1'($urandom);
      txData = 3'($urandom);
      cyc();
    end
  endtask

  task automatic loadGci(int side);
    wr(side, 0, mk(6, 0, 0, 1, 0));  // 8 bits to mgmt 2
    wr(side, 1, mk(0, 1, 0, 1, 0));  // 8 bits external device
    wr(side, 2, mk(5, 0, 0, 1, 0));  // 8 bits to mgmt 1
    wr(side, 3, mk(2, 0, 1, 0, 0));  // 2 bits to D channel
    wr(side, 4, mk(5, 0, 5, 0, 0));  // 6 bits to mgmt 1
    wr(side, 5, mk(0, 0, 6, 1, 0));  // skip 56 bits
    wr(side, 6, mk(0, 0, 1, 0, 0));  // skip 2 bits
    wr(side, 7, mk(7, 0, 0, 0, 1));  // grant bit, last
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    // R2: reset state
    chk(rxValid == 0 && txReq == 0 && txLine == 1 && dGrant == 0, "R2 reset state",
        {rxValid, txReq, txLine, dGrant}, 8'b0000_0010);

    loadGci(0);
    loadGci(1);
    enable = 1'b1;
    cyc();

    // R3/R5/R6: several frames with the grant forced to alternating values
    for (int f = 0; f < 3; f++) begin
      bit g;
      g = (f != 1);
      frame(95, g, 1);
      chk(cRx[2] == 8, "R3 mgmt2 byte run", cRx[2], 8);
      chk(cRx[1] == 14, "R3 mgmt1 byte+6 bits", cRx[1], 14);
      chk(cRx[0] == 2, "R3 D 2-bit run", cRx[0], 2);
      chk(cRxStb == 8 && cTxStb == 8, "R5 strobe slot", cRxStb + cTxStb, 16);
      chk(dGrant == g, "R6 grant captured", dGrant, g);
      chk(cLineLow == 0, "R9 released when unrouted", cLineLow, 0);
    end
    // R6: grant held into the next frame's start
    frame(20, 1'b0, 1);
    chk(dGrant == 1'b1, "R6 grant held", dGrant, 1);

    // R1: write while enabled is ignored
    wr(1, 0, mk(0, 0, 0, 1, 0));
    frame(95, 1'b0, 1);
    chk(cTx[2] == 8, "R1 enabled write ignored", cTx[2], 8);

    // R11: change tx only, rx unchanged
    enable = 1'b0; cyc();
    wr(1, 0, mk(2, 0, 0, 1, 0));
    enable = 1'b1; cyc();
    frame(95, 1'b1, 1);
    chk(cTx[0] == 10 && cTx[2] == 0, "R11 tx table changed", cTx[0], 10);
    chk(cRx[2] == 8, "R11 rx table kept", cRx[2], 8);

    // R7: last flag at entry 2, then table without last flag
    enable = 1'b0; cyc();
    for (int i = 0; i < DEPTH; i++) wr(0, i, mk(5, 0, 0, 0, (i == 2) ? 1 : 0));
    enable = 1'b1; cyc();
    frame(40, 1'b0, 1);
    chk(cRx[1] == 3, "R7 stop at last flag", cRx[1], 3);
    enable = 1'b0; cyc();
    wr(0, 2, mk(5, 0, 0, 0, 0));
    enable = 1'b1; cyc();
    frame(40, 1'b0, 1);
    chk(cRx[1] == DEPTH, "R7 stop at table end", cRx[1], DEPTH);

    // R8: an entry longer than the frame
    enable = 1'b0; cyc();
    wr(0, 0, mk(6, 2, 15, 1, 1));
    enable = 1'b1; cyc();
    frame(130, 1'b0, 1);
    chk(cRx[2] == FRAME_BITS, "R8 frame cap", cRx[2], FRAME_BITS);

    // R10: sync in mid-run restarts; back-to-back after the cap too
    frame(19, 1'b0, 1);
    frame(130, 1'b0, 0);
    chk(cRx[2] == 20 + FRAME_BITS, "R10 resync mid-frame", cRx[2], 20 + FRAME_BITS);
    frame(FRAME_BITS, 1'b0, 1);
    frame(5, 1'b0, 0);
    chk(cRx[2] == FRAME_BITS + 6, "R10 resync after cap", cRx[2], FRAME_BITS + 6);

    // R2: enable dropped mid-frame
    clearCounts();
    frameSync = 1'b1; cyc();
    frameSync = 1'b0;
    repeat (9) cyc();
    enable = 1'b0;
    repeat (20) cyc();
    chk(cRx[2] == 10, "R2 enable drop stops", cRx[2], 10);
    // R2: sync without enable does not start
    clearCounts();
    frame(30, 1'b0, 1);
    chk(cRx[2] == 0, "R2 sync ignored when disabled", cRx[2], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule